// File: doc/BRIEF.md
# Crypto Length Tracker and Start Trigger

This block keeps the byte-length context of a block-cipher job and decides when the job starts and when it ends. The host writes a 61-bit payload length as two 32-bit words and a 32-bit authentication length. The host also selects one of four job classes: a plain cipher mode, one of two combined authenticated modes, or the tweaked storage mode. While a job runs, a datapath reports each 16-byte block it consumes. The tracker counts the matching length down by up to 16 bytes per block and raises a one-cycle completion pulse when nothing finite remains.

Which register write launches the job depends on the class. In the plain and tweaked classes the upper payload word launches it. In the combined classes the authentication-length write launches it. In the tweaked class the authentication register is not a length. It carries a 28-bit block index, which the block passes out and advances once per consumed block. A zero payload in the plain class means an endless stream. Host reads of the length context always return zero. Illegal starts, and writes that arrive during a job, raise a sticky error.

Top module: `crypto_len_tracker`

## Requirements
- R1: The payload length is 61 bits. A write with `wr_sel_i`=0 replaces bits [31:0]. A write with `wr_sel_i`=1 replaces bits [60:32] with `wr_data_i[28:0]`, and the upper three data bits are dropped. `wr_sel_i`=2 addresses the authentication register, and `wr_sel_i`=3 is no register.
- R2: With `mode_i`=0 (plain) or 3 (tweaked), an idle write with `wr_sel_i`=1 launches the job: `start_o` is high for exactly the next cycle and `busy_o` rises in that same cycle.
- R3: With `mode_i`=1 or 2 (combined), an upper-word write does not launch the job. An idle write with `wr_sel_i`=2 loads the authentication length and launches it.
- R4: Each `blk_valid_i` cycle during a job subtracts min(16, remaining) from one length. In combined modes the authentication length is reduced first, and the payload only once the authentication length is zero.
- R5: When the last finite length reaches zero, `done_o` is high for exactly one cycle and `busy_o` falls in that same cycle.
- R6: In plain mode, a zero payload at launch sets `infinite_o`. Block reports then leave the payload unchanged, `busy_o` stays high and `done_o` never rises.
- R7: In combined modes, one length may be zero. If both are zero at launch, the job does not start and `err_o` is set.
- R8: In tweaked mode, a `wr_sel_i`=2 write loads `xts_index_o` from `wr_data_i[31:4]` and leaves the authentication length unchanged. The index increments by one for each consumed block. A zero payload at launch is rejected with `err_o`.
- R9: `rd_data_o` reads as zero at all times.
- R10: In mode 1 (counter-based combined), a payload above 2^36-32 bytes at launch is rejected with `err_o`. Exactly 2^36-32 bytes is accepted.
- R11: A register write (`wr_sel_i` 0..2) during a job leaves every length unchanged and sets `err_o`. `err_o` stays set until reset.
- R12: After reset, all lengths, the index and every flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Job class: 0 plain, 1 counter combined, 2 chained combined, 3 tweaked |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for the write |
| wr_data_i | input | 32 | Write data |
| blk_valid_i | input | 1 | One 16-byte block consumed this cycle |
| start_o | output | 1 | One-cycle launch pulse |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky error |
| infinite_o | output | 1 | Current job has no payload end |
| pay_remain_o | output | 61 | Remaining payload bytes |
| auth_remain_o | output | 32 | Remaining authentication bytes |
| xts_index_o | output | 28 | Tweaked-mode block index |
| rd_data_o | output | 32 | Host read data for the length context |

## Verification
Two functions can land in one clock edge: the final block report that completes a job, and a host register write. At that edge the block still counts as busy, so the write must be dropped. The bench provokes this by driving `blk_valid_i` and a low-word write in the same cycle as the last block of a 16-byte job. It then expects `done_o` high, `busy_o` low, `err_o` set and the payload still zero on the following cycle.

// File: rtl/crypto_len_pkg.sv
package crypto_len_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN      = 2'd0,
    MODE_AEAD_CTR   = 2'd1,
    MODE_AEAD_CHAIN = 2'd2,
    MODE_TWEAK      = 2'd3
  } job_mode_e;

  typedef enum logic [1:0] {
    SEL_PAY_LO = 2'd0,
    SEL_PAY_HI = 2'd1,
    SEL_AUTH   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  function automatic logic is_combined(job_mode_e m);
    return (m == MODE_AEAD_CTR) || (m == MODE_AEAD_CHAIN);
  endfunction

endpackage

// File: rtl/len_downcounter.sv
module len_downcounter #(
  parameter int W         = 32,
  parameter int BLK_BYTES = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic         dec_en,
  output logic [W-1:0] remain,
  output logic         is_zero,
  output logic         is_last
);

  localparam logic [W-1:0] STEP = W'(BLK_BYTES);

  logic [W-1:0] remain_q, remain_nx;

  always_comb begin
    remain_nx = remain_q;
    if (ld_en) begin
      remain_nx = ld_val;
    end else if (dec_en) begin
      remain_nx = (remain_q > STEP) ? (remain_q - STEP) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (ld_en || dec_en) begin
      remain_q <= remain_nx;
    end
  end

  assign remain  = remain_q;
  assign is_zero = (remain_q == '0);
  assign is_last = !is_zero && (remain_q <= STEP);

  assert_no_grow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !ld_en) |=> (remain <= $past(remain)));

  assert_last_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !ld_en && is_last) |=> is_zero);

endmodule

// File: rtl/tweak_index_reg.sv
module tweak_index_reg #(
  parameter int IDX_W  = 28,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [WORD_W-1:0] word,
  input  logic              step_en,
  output logic [IDX_W-1:0]  idx
);

  localparam int LSB = WORD_W - IDX_W;

  logic [IDX_W-1:0] idx_q, idx_nx;

  always_comb begin
    idx_nx = idx_q;
    if (ld_en) begin
      idx_nx = word[WORD_W-1:LSB];
    end else if (step_en) begin
      idx_nx = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (ld_en || step_en) begin
      idx_q <= idx_nx;
    end
  end

  assign idx = idx_q;

  assert_index_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (idx == $past(word[WORD_W-1:LSB])));

  assert_index_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !step_en) |=> $stable(idx));

endmodule

// File: rtl/len_job_ctrl.sv
module len_job_ctrl
  import crypto_len_pkg::*;
#(
  parameter int PAY_W      = 61,
  parameter int WORD_W     = 32,
  parameter int BLK_BYTES  = 16,
  parameter int CTR_LOG2   = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  job_mode_e         mode,
  input  logic              wr_en,
  input  reg_sel_e          wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              blk_valid,
  input  logic [PAY_W-1:0]  pay_remain,
  input  logic              pay_zero,
  input  logic              pay_last,
  input  logic              auth_zero,
  input  logic              auth_last,
  output logic              pay_ld,
  output logic              auth_ld,
  output logic              idx_ld,
  output logic              pay_dec,
  output logic              auth_dec,
  output logic              idx_step,
  output logic              start,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              infinite
);

  localparam int HI_BITS = PAY_W - WORD_W;
  localparam logic [PAY_W-1:0] CTR_CAP =
    (PAY_W'(1) << CTR_LOG2) - PAY_W'(2 * BLK_BYTES);

  logic      busy_q, busy_nx;
  logic      start_q, start_nx;
  logic      done_q, done_nx;
  logic      err_q, err_nx;
  logic      inf_q, inf_nx;
  job_mode_e jmode_q, jmode_nx;

  logic idle_wr, busy_wr, hi_new_zero, go_hi, go_auth, reject, launch;
  logic consume, auth_first, finish;

  always_comb begin
    idle_wr     = wr_en && !busy_q;
    busy_wr     = wr_en && busy_q && (wr_sel != SEL_NONE);
    pay_ld      = idle_wr && ((wr_sel == SEL_PAY_LO) || (wr_sel == SEL_PAY_HI));
    auth_ld     = idle_wr && (wr_sel == SEL_AUTH) && (mode != MODE_TWEAK);
    idx_ld      = idle_wr && (wr_sel == SEL_AUTH) && (mode == MODE_TWEAK);
    hi_new_zero = (wr_data[HI_BITS-1:0] == '0) && (pay_remain[WORD_W-1:0] == '0);
    go_hi       = idle_wr && (wr_sel == SEL_PAY_HI) &&
                  ((mode == MODE_PLAIN) || (mode == MODE_TWEAK));
    go_auth     = idle_wr && (wr_sel == SEL_AUTH) && is_combined(mode);
    reject      = (go_hi && (mode == MODE_TWEAK) && hi_new_zero) ||
                  (go_auth && (wr_data == '0) && pay_zero) ||
                  (go_auth && (mode == MODE_AEAD_CTR) && (pay_remain > CTR_CAP));
    launch      = (go_hi || go_auth) && !reject;

    consume     = busy_q && blk_valid;
    auth_first  = is_combined(jmode_q) && !auth_zero;
    auth_dec    = consume && auth_first;
    pay_dec     = consume && !auth_first && !inf_q;
    idx_step    = consume && (jmode_q == MODE_TWEAK);
    finish      = auth_dec ? (auth_last && pay_zero) : (pay_dec && pay_last);
  end

  always_comb begin
    busy_nx  = busy_q;
    jmode_nx = jmode_q;
    inf_nx   = inf_q;
    if (launch) begin
      busy_nx  = 1'b1;
      jmode_nx = mode;
      inf_nx   = go_hi && (mode == MODE_PLAIN) && hi_new_zero;
    end else if (finish) begin
      busy_nx  = 1'b0;
    end
    start_nx = launch;
    done_nx  = finish;
    err_nx   = err_q || busy_wr || ((go_hi || go_auth) && reject);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      inf_q   <= 1'b0;
      jmode_q <= MODE_PLAIN;
    end else begin
      busy_q  <= busy_nx;
      start_q <= start_nx;
      done_q  <= done_nx;
      err_q   <= err_nx;
      if (launch) begin
        inf_q   <= inf_nx;
        jmode_q <= jmode_nx;
      end
    end
  end

  assign start    = start_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;
  assign infinite = inf_q;

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_inf_no_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && infinite) |=> !done);

  assert_busy_write_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy && (wr_sel != SEL_NONE)) |=> err);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: rtl/crypto_len_tracker.sv
module crypto_len_tracker
  import crypto_len_pkg::*;
#(
  parameter int PAY_W     = 61,
  parameter int AUTH_W    = 32,
  parameter int WORD_W    = 32,
  parameter int IDX_W     = 28,
  parameter int BLK_BYTES = 16,
  parameter int CTR_LOG2  = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              blk_valid_i,
  output logic              start_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              infinite_o,
  output logic [PAY_W-1:0]  pay_remain_o,
  output logic [AUTH_W-1:0] auth_remain_o,
  output logic [IDX_W-1:0]  xts_index_o,
  output logic [WORD_W-1:0] rd_data_o
);

  localparam int HI_BITS = PAY_W - WORD_W;

  job_mode_e        mode;
  reg_sel_e         sel;
  logic             pay_ld, auth_ld, idx_ld, pay_dec, auth_dec, idx_step;
  logic             pay_zero, pay_last, auth_zero, auth_last;
  logic [PAY_W-1:0] pay_ld_val;

  assign mode = job_mode_e'(mode_i);
  assign sel  = reg_sel_e'(wr_sel_i);

  always_comb begin
    if (sel == SEL_PAY_HI) begin
      pay_ld_val = {wr_data_i[HI_BITS-1:0], pay_remain_o[WORD_W-1:0]};
    end else begin
      pay_ld_val = {pay_remain_o[PAY_W-1:WORD_W], wr_data_i};
    end
  end

  len_job_ctrl #(
    .PAY_W(PAY_W), .WORD_W(WORD_W), .BLK_BYTES(BLK_BYTES), .CTR_LOG2(CTR_LOG2)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en_i), .wr_sel(sel),
    .wr_data(wr_data_i), .blk_valid(blk_valid_i), .pay_remain(pay_remain_o),
    .pay_zero(pay_zero), .pay_last(pay_last), .auth_zero(auth_zero),
    .auth_last(auth_last), .pay_ld(pay_ld), .auth_ld(auth_ld), .idx_ld(idx_ld),
    .pay_dec(pay_dec), .auth_dec(auth_dec), .idx_step(idx_step),
    .start(start_o), .busy(busy_o), .done(done_o), .err(err_o),
    .infinite(infinite_o)
  );

  len_downcounter #(.W(PAY_W), .BLK_BYTES(BLK_BYTES)) u_pay (
    .clk(clk), .rst_n(rst_n), .ld_en(pay_ld), .ld_val(pay_ld_val),
    .dec_en(pay_dec), .remain(pay_remain_o), .is_zero(pay_zero),
    .is_last(pay_last)
  );

  len_downcounter #(.W(AUTH_W), .BLK_BYTES(BLK_BYTES)) u_auth (
    .clk(clk), .rst_n(rst_n), .ld_en(auth_ld), .ld_val(AUTH_W'(wr_data_i)),
    .dec_en(auth_dec), .remain(auth_remain_o), .is_zero(auth_zero),
    .is_last(auth_last)
  );

  tweak_index_reg #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .ld_en(idx_ld), .word(wr_data_i),
    .step_en(idx_step), .idx(xts_index_o)
  );

  assign rd_data_o = '0;

  assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pay_dec && auth_dec));

  assert_index_auth_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && sel == SEL_AUTH && mode == MODE_TWEAK) |=> $stable(auth_remain_o));

endmodule

// File: tb/tb_crypto_len_tracker.sv
`timescale 1ns/1ps
module tb_crypto_len_tracker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic        wr_en_i;
  logic [1:0]  wr_sel_i;
  logic [31:0] wr_data_i;
  logic        blk_valid_i;
  logic        start_o, busy_o, done_o, err_o, infinite_o;
  logic [60:0] pay_remain_o;
  logic [31:0] auth_remain_o;
  logic [27:0] xts_index_o;
  logic [31:0] rd_data_o;

  always #2 clk = ~clk;

  crypto_len_tracker dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .blk_valid_i(blk_valid_i),
    .start_o(start_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .infinite_o(infinite_o), .pay_remain_o(pay_remain_o),
    .auth_remain_o(auth_remain_o), .xts_index_o(xts_index_o),
    .rd_data_o(rd_data_o)
  );

  typedef struct {
    string       req;
    int          which;
    logic [63:0] val;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;

  function automatic logic [63:0] observe(int which);
    case (which)
      0: return 64'(start_o);
      1: return 64'(busy_o);
      2: return 64'(done_o);
      3: return 64'(err_o);
      4: return 64'(pay_remain_o);
      5: return 64'(auth_remain_o);
      6: return 64'(xts_index_o);
      7: return 64'(rd_data_o);
      default: return 64'(infinite_o);
    endcase
  endfunction

  // monitor: pops expected items and compares with the design's outputs
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        logic [63:0] got;
        e = q.pop_front();
        got = observe(e.which);
        checks++;
        if (got !== e.val) begin
          errors++;
          $display("FAIL %s sig%0d actual=%0h expected=%0h", e.req, e.which, got, e.val);
        end
      end
    end
  end

  task automatic expect_val(string req, int which, logic [63:0] val);
    exp_t e;
    e.req = req; e.which = which; e.val = val;
    q.push_back(e);
    ->chk_ev;
    #0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en_i = 1'b0; blk_valid_i = 1'b0;
    wr_sel_i = 2'd3; wr_data_i = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic step(logic we, logic [1:0] sel, logic [31:0] data, logic blk);
    @(negedge clk);
    wr_en_i = we; wr_sel_i = sel; wr_data_i = data; blk_valid_i = blk;
    @(negedge clk);
    wr_en_i = 1'b0; blk_valid_i = 1'b0;
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    step(1'b1, sel, data, 1'b0);
  endtask

  task automatic blk();
    step(1'b0, 2'd3, 32'h0, 1'b1);
  endtask

  task automatic finish_run();
    #1;
    if (q.size() > 0) begin
      errors++;
      $display("FAIL unchecked items remain: actual=%0d expected=0", q.size());
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mode_i = 2'd0;
    do_reset();
    // R12 reset state
    expect_val("R12", 0, 0); expect_val("R12", 1, 0); expect_val("R12", 2, 0);
    expect_val("R12", 3, 0); expect_val("R12", 4, 0); expect_val("R12", 5, 0);
    expect_val("R12", 6, 0); expect_val("R12", 8, 0);

    // R1 / R2: width split, upper bits dropped, plain launch
    wr(2'd0, 32'h1234_5678);
    expect_val("R2", 1, 0);
    wr(2'd1, 32'hFFFF_FFFF);
    expect_val("R1", 4, {3'b0, 29'h1FFF_FFFF, 32'h1234_5678});
    expect_val("R2", 0, 1); expect_val("R2", 1, 1);
    expect_val("R9", 7, 0);
    @(negedge clk);
    expect_val("R2", 0, 0);

    // R4 / R5 / R11: plain countdown with a partial final block
    do_reset();
    wr(2'd0, 32'd40); wr(2'd1, 32'd0);
    expect_val("R2", 1, 1);
    blk(); expect_val("R4", 4, 24);
    wr(2'd0, 32'h1000);
    expect_val("R11", 4, 24); expect_val("R11", 3, 1);
    blk(); expect_val("R4", 4, 8);
    blk(); expect_val("R4", 4, 0); expect_val("R5", 2, 1); expect_val("R5", 1, 0);
    @(negedge clk);
    expect_val("R5", 2, 0); expect_val("R11", 3, 1);

    // R6: infinite plain stream
    do_reset();
    wr(2'd0, 32'd0); wr(2'd1, 32'd0);
    expect_val("R6", 8, 1); expect_val("R6", 1, 1);
    for (int i = 0; i < 5; i++) begin
      blk(); expect_val("R6", 2, 0);
    end
    expect_val("R6", 1, 1); expect_val("R6", 4, 0);

    // R3 / R4: counter combined, auth first
    do_reset();
    mode_i = 2'd1;
    wr(2'd0, 32'd20); wr(2'd1, 32'd0);
    expect_val("R3", 1, 0); expect_val("R3", 0, 0);
    wr(2'd2, 32'd16);
    expect_val("R3", 0, 1); expect_val("R3", 5, 16);
    blk(); expect_val("R4", 5, 0); expect_val("R4", 4, 20);
    blk(); expect_val("R4", 4, 4); expect_val("R5", 2, 0);
    blk(); expect_val("R5", 2, 1); expect_val("R5", 1, 0);

    // R7: both zero rejected, auth-only job accepted
    do_reset();
    mode_i = 2'd2;
    wr(2'd2, 32'd0);
    expect_val("R7", 1, 0); expect_val("R7", 3, 1);
    do_reset();
    wr(2'd2, 32'd33);
    expect_val("R7", 1, 1); expect_val("R7", 3, 0);
    blk(); expect_val("R4", 5, 17);
    blk(); expect_val("R4", 5, 1);
    blk(); expect_val("R7", 2, 1); expect_val("R7", 5, 0);

    // R10: counter combined payload cap boundary
    do_reset();
    mode_i = 2'd1;
    wr(2'd0, 32'hFFFF_FFE0); wr(2'd1, 32'h0000_000F); wr(2'd2, 32'd0);
    expect_val("R10", 1, 1); expect_val("R10", 3, 0);
    do_reset();
    wr(2'd0, 32'hFFFF_FFF0); wr(2'd1, 32'h0000_000F); wr(2'd2, 32'd0);
    expect_val("R10", 1, 0); expect_val("R10", 3, 1);

    // R8: tweaked index load and stepping
    do_reset();
    mode_i = 2'd3;
    wr(2'd2, 32'hABCD_E5F7);
    expect_val("R8", 6, 28'hABCDE5F); expect_val("R8", 5, 0); expect_val("R8", 1, 0);
    wr(2'd0, 32'd32); wr(2'd1, 32'd0);
    expect_val("R8", 1, 1);
    blk(); expect_val("R8", 6, 28'hABCDE60); expect_val("R8", 4, 16);
    blk(); expect_val("R8", 6, 28'hABCDE61); expect_val("R5", 2, 1);
    do_reset();
    wr(2'd1, 32'd0);
    expect_val("R8", 1, 0); expect_val("R8", 3, 1);

    // R11 with R5: final block and a write at the same edge
    do_reset();
    mode_i = 2'd0;
    wr(2'd0, 32'd16); wr(2'd1, 32'd0);
    step(1'b1, 2'd0, 32'h99, 1'b1);
    expect_val("R5", 2, 1); expect_val("R5", 1, 0);
    expect_val("R11", 3, 1); expect_val("R11", 4, 0);
    expect_val("R9", 7, 0);

    finished = 1;
    finish_run();
  end

endmodule